// File: doc/BRIEF.md
# Debug Matchpoint Comparator Bank

This block watches the processor's memory traffic for a debugger. It holds a bank of matchpoints. Each matchpoint has a data value register and a control register. The control register says whether the matchpoint is armed, which kinds of bus event it watches, which comparison it makes, and whether relational comparisons treat the operands as two's-complement numbers.

On each cycle in which the event strobe is high, every matchpoint compares the event's data word with its own value register. An event is an instruction fetch address, a load or store address, or a load or store data word. The per-matchpoint results are registered and appear on a hit vector one cycle later. A single any-hit flag is registered with them. Chaining of hits into watchpoints and the event counters belong to a neighbouring block.

Configuration arrives through a one-cycle write port. Address bit 0 selects the control register (1) or the value register (0). The address bits above it give the matchpoint index.

Top module: `dbg_match_bank`

## Requirements
- R1: While reset is asserted and after it is released, every value and control register is zero and `hit_o` and `any_hit_o` are zero. An event sent before any configuration write produces no hit.
- R2: A matchpoint whose armed bit (control bit 0) is 0 never hits, whatever its other fields and whatever the event.
- R3: The trigger field in control bits [3:1] selects the events the matchpoint watches. The codes are: 1 fetch address, 2 load address, 3 store address, 4 load data, 5 store data, 6 load or store address, 7 load or store data. The event kind input is encoded 0 fetch address, 1 load address, 2 store address, 3 load data, 4 store data. A matchpoint only hits on an event whose kind its trigger covers.
- R4: An event whose kind is 5, 6 or 7 produces no hit on any matchpoint.
- R5: Condition code 1 in control bits [6:4] (masked) hits when the bitwise AND of the event data and the value register is nonzero.
- R6: Condition code 2 hits when the event data equals the value register. Condition code 3 hits when they differ.
- R7: With the signed bit (control bit 7) clear, condition codes 4, 5, 6 and 7 hit when the event data is less than, less than or equal to, greater than, or greater than or equal to the value register, using unsigned ordering.
- R8: With the signed bit set, the same four condition codes use two's-complement ordering. The signed bit does not change the result of codes 1, 2 and 3.
- R9: Condition code 0 and trigger code 0 never produce a hit.
- R10: `hit_o` reflects the event presented on the previous clock edge. A cycle with the strobe low gives an all-zero `hit_o` one cycle later.
- R11: `any_hit_o` is high exactly when at least one bit of `hit_o` is high.
- R12: A configuration write changes only the addressed register of the addressed matchpoint. An event presented in the same cycle as a write is compared against the configuration that was in place before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Bit 0 selects control (1) or value (0). Bits [3:1] give the matchpoint index |
| cfg_wdata | input | 32 | Write data. Control registers keep bits [7:0] |
| ev_valid | input | 1 | Bus event strobe |
| ev_kind | input | 3 | Event kind, encoded as in R3 |
| ev_data | input | 32 | Event address or data word |
| hit_o | output | 8 | Registered per-matchpoint hit flags |
| any_hit_o | output | 1 | Registered OR of the hit flags |

## Verification
The assertions assume that the strobe, the kind and the write port carry known values at every rising edge after reset. They also assume that the kind field may take its reserved codes, and the checker relies on those codes never producing a hit. The stimulus drives every input to a defined value from time zero and changes inputs only on the falling clock edge. It sends reserved kinds on purpose, so the no-hit rules for those codes are exercised rather than avoided.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

    // Event kind presented with each strobe
    typedef enum logic [2:0] {
        EV_FETCH   = 3'd0,
        EV_LD_ADDR = 3'd1,
        EV_ST_ADDR = 3'd2,
        EV_LD_DATA = 3'd3,
        EV_ST_DATA = 3'd4,
        EV_RSV5    = 3'd5,
        EV_RSV6    = 3'd6,
        EV_RSV7    = 3'd7
    } ev_kind_e;

    // Which events a matchpoint watches
    typedef enum logic [2:0] {
        TR_OFF     = 3'd0,
        TR_FETCH   = 3'd1,
        TR_LD_ADDR = 3'd2,
        TR_ST_ADDR = 3'd3,
        TR_LD_DATA = 3'd4,
        TR_ST_DATA = 3'd5,
        TR_LS_ADDR = 3'd6,
        TR_LS_DATA = 3'd7
    } trig_e;

    // Comparison performed
    typedef enum logic [2:0] {
        CD_NONE = 3'd0,
        CD_MASK = 3'd1,
        CD_EQ   = 3'd2,
        CD_NE   = 3'd3,
        CD_LT   = 3'd4,
        CD_LE   = 3'd5,
        CD_GT   = 3'd6,
        CD_GE   = 3'd7
    } cond_e;

    // Control register layout, bit 0 at the bottom
    typedef struct packed {
        logic  sgn;      // bit 7
        cond_e cond;     // bits 6:4
        trig_e trig;     // bits 3:1
        logic  armed;    // bit 0
    } mp_ctrl_t;

    localparam int unsigned CTRL_W = $bits(mp_ctrl_t);

endpackage

// File: rtl/dbg_match_cfg.sv
module dbg_match_cfg
    import dbg_match_pkg::*;
#(
    parameter int unsigned NUM_MP = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = (NUM_MP > 1) ? $clog2(NUM_MP) : 1,
    localparam int unsigned ADDR_W = IDX_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_MP-1:0][DATA_W-1:0]    val_o,
    output mp_ctrl_t [NUM_MP-1:0]            ctrl_o
);

    typedef struct packed {
        logic [NUM_MP-1:0][DATA_W-1:0] val;
        mp_ctrl_t [NUM_MP-1:0]         ctrl;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    logic [IDX_W-1:0] wr_idx;
    logic             wr_ctrl_sel;

    assign wr_idx      = wr_addr[ADDR_W-1:1];
    assign wr_ctrl_sel = wr_addr[0];

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_MP; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                if (wr_ctrl_sel) begin
                    state_d.ctrl[i] = mp_ctrl_t'(wr_data[CTRL_W-1:0]);
                end else begin
                    state_d.val[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign val_o  = state_q.val;
    assign ctrl_o = state_q.ctrl;

endmodule

// File: rtl/dbg_match_cmp.sv
module dbg_match_cmp
    import dbg_match_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  mp_ctrl_t            ctrl,
    input  logic [DATA_W-1:0]   value,
    input  logic [2:0]          ev_kind,
    input  logic [DATA_W-1:0]   ev_data,
    output logic                hit
);

    logic     kind_ok;
    logic     cond_ok;
    logic     is_eq;
    logic     is_lt;
    ev_kind_e kind;

    assign kind = ev_kind_e'(ev_kind);

    // Trigger selection against the incoming event kind
    always_comb begin
        unique case (ctrl.trig)
            TR_FETCH:   kind_ok = (kind == EV_FETCH);
            TR_LD_ADDR: kind_ok = (kind == EV_LD_ADDR);
            TR_ST_ADDR: kind_ok = (kind == EV_ST_ADDR);
            TR_LD_DATA: kind_ok = (kind == EV_LD_DATA);
            TR_ST_DATA: kind_ok = (kind == EV_ST_DATA);
            TR_LS_ADDR: kind_ok = (kind == EV_LD_ADDR) || (kind == EV_ST_ADDR);
            TR_LS_DATA: kind_ok = (kind == EV_LD_DATA) || (kind == EV_ST_DATA);
            default:    kind_ok = 1'b0;
        endcase
    end

    // One magnitude comparator serves all four ordering conditions
    always_comb begin
        is_eq = (ev_data == value);
        if (ctrl.sgn) begin
            is_lt = ($signed(ev_data) < $signed(value));
        end else begin
            is_lt = (ev_data < value);
        end
    end

    always_comb begin
        unique case (ctrl.cond)
            CD_MASK: cond_ok = |(ev_data & value);
            CD_EQ:   cond_ok = is_eq;
            CD_NE:   cond_ok = !is_eq;
            CD_LT:   cond_ok = is_lt;
            CD_LE:   cond_ok = is_lt || is_eq;
            CD_GT:   cond_ok = !is_lt && !is_eq;
            CD_GE:   cond_ok = !is_lt;
            default: cond_ok = 1'b0;
        endcase
    end

    assign hit = ctrl.armed && kind_ok && cond_ok;

endmodule

// File: rtl/dbg_match_bank.sv
module dbg_match_bank
    import dbg_match_pkg::*;
#(
    parameter int unsigned NUM_MP = 8,
    parameter int unsigned DATA_W = 32,
    localparam int unsigned IDX_W = (NUM_MP > 1) ? $clog2(NUM_MP) : 1,
    localparam int unsigned ADDR_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               ev_valid,
    input  logic [2:0]         ev_kind,
    input  logic [DATA_W-1:0]  ev_data,
    output logic [NUM_MP-1:0]  hit_o,
    output logic               any_hit_o
);

    typedef struct packed {
        logic [NUM_MP-1:0] hit;
        logic              any;
    } res_state_t;

    logic [NUM_MP-1:0][DATA_W-1:0] mp_val;
    mp_ctrl_t [NUM_MP-1:0]         mp_ctrl;
    logic [NUM_MP-1:0]             raw_hit;

    res_state_t res_d, res_q;

    dbg_match_cfg #(
        .NUM_MP (NUM_MP),
        .DATA_W (DATA_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .val_o   (mp_val),
        .ctrl_o  (mp_ctrl)
    );

    for (genvar g = 0; g < NUM_MP; g++) begin : g_cmp
        dbg_match_cmp #(
            .DATA_W (DATA_W)
        ) u_cmp (
            .ctrl    (mp_ctrl[g]),
            .value   (mp_val[g]),
            .ev_kind (ev_kind),
            .ev_data (ev_data),
            .hit     (raw_hit[g])
        );
    end

    always_comb begin
        res_d     = '0;
        if (ev_valid) begin
            res_d.hit = raw_hit;
            res_d.any = |raw_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign hit_o     = res_q.hit;
    assign any_hit_o = res_q.any;

endmodule

// File: rtl/dbg_match_bank_chk.sv
module dbg_match_bank_chk #(
    parameter int unsigned NUM_MP = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic [2:0]        ev_kind,
    input logic [NUM_MP-1:0] hit_o,
    input logic              any_hit_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (hit_o == '0) && !any_hit_o);

    // R11
    any_is_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit_o == (hit_o != '0));

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> (hit_o == '0));

    // R4
    bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && (ev_kind > 3'd4)) |=> (hit_o == '0));

endmodule

bind dbg_match_bank dbg_match_bank_chk #(
    .NUM_MP (NUM_MP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_kind   (ev_kind),
    .hit_o     (hit_o),
    .any_hit_o (any_hit_o)
);

// File: tb/tb_dbg_match_bank.sv
`timescale 1ns/1ps
module tb_dbg_match_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_kind = '0;
    logic [31:0] ev_data = '0;
    logic [7:0]  hit_o;
    logic        any_hit_o;

    int n_run = 0;
    int n_fail = 0;

    logic [7:0]  sh_ctrl [8];
    logic [31:0] sh_val  [8];

    always #10 clk = ~clk;

    dbg_match_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ev_valid  (ev_valid),
        .ev_kind   (ev_kind),
        .ev_data   (ev_data),
        .hit_o     (hit_o),
        .any_hit_o (any_hit_o)
    );

    function automatic logic [7:0] mk_ctrl(bit sg, int cd, int tr, bit en);
        return {sg, cd[2:0], tr[2:0], en};
    endfunction

    // Expected hit of one matchpoint, written from the requirements
    function automatic bit ref_hit(logic [7:0] c, logic [31:0] v, int k, logic [31:0] d);
        bit tok, cok, lt, eq;
        case (int'(c[3:1]))
            1: tok = (k == 0);
            2: tok = (k == 1);
            3: tok = (k == 2);
            4: tok = (k == 3);
            5: tok = (k == 4);
            6: tok = (k == 1) || (k == 2);
            7: tok = (k == 3) || (k == 4);
            default: tok = 0;
        endcase
        eq = (d == v);
        lt = c[7] ? ($signed(d) < $signed(v)) : (d < v);
        case (int'(c[6:4]))
            1: cok = ((d & v) != 0);
            2: cok = eq;
            3: cok = !eq;
            4: cok = lt;
            5: cok = lt || eq;
            6: cok = !lt && !eq;
            7: cok = !lt;
            default: cok = 0;
        endcase
        return c[0] && tok && cok;
    endfunction

    function automatic logic [7:0] ref_vec(int k, logic [31:0] d);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ref_hit(sh_ctrl[i], sh_val[i], k, d);
        return r;
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp, logic got_any);
        n_run++;
        if (got !== exp || got_any !== (exp != 0)) begin
            n_fail++;
            $display("FAIL %s: hit=%b any=%b expected hit=%b any=%b",
                     req, got, got_any, exp, (exp != 0));
        end
    endtask

    task automatic write_cfg(int idx, bit is_ctrl, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = {idx[2:0], is_ctrl};
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (is_ctrl) sh_ctrl[idx] = d[7:0];
        else sh_val[idx] = d;
    endtask

    task automatic send_event(int k, logic [31:0] d, string req);
        logic [7:0] exp;
        @(negedge clk);
        ev_valid = 1'b1;
        ev_kind = k[2:0];
        ev_data = d;
        exp = ref_vec(k, d);
        @(negedge clk);
        check(req, hit_o, exp, any_hit_o);
        ev_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 during reset", hit_o, 8'h00, any_hit_o);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", hit_o, 8'h00, any_hit_o);
        send_event(0, 32'h0, "R1 unconfigured fetch");
        send_event(3, 32'hFFFF_FFFF, "R1 unconfigured load data");
    endtask

    task automatic t_armed;
        write_cfg(0, 0, 32'd5);
        write_cfg(0, 1, {24'hFFFFFF, mk_ctrl(0, 2, 1, 0)});
        send_event(0, 32'd5, "R2 disarmed equal");
        write_cfg(0, 1, mk_ctrl(0, 2, 1, 1));
        send_event(0, 32'd5, "R6 armed equal");
        send_event(0, 32'd6, "R6 armed unequal");
        write_cfg(0, 1, 32'h0);
    endtask

    task automatic t_triggers;
        for (int i = 0; i < 8; i++) begin
            write_cfg(i, 0, 32'h0);
            write_cfg(i, 1, mk_ctrl(0, 7, i, 1));
        end
        for (int k = 0; k < 8; k++) begin
            send_event(k, 32'h1234, (k > 4) ? "R4 reserved kind" : "R3 R9 trigger select");
        end
    endtask

    task automatic t_conds(bit sg, logic [31:0] v, string req);
        for (int i = 0; i < 8; i++) begin
            write_cfg(i, 0, v);
            write_cfg(i, 1, mk_ctrl(sg, i, 4, 1));
        end
        send_event(3, v - 32'd1, req);
        send_event(3, v, req);
        send_event(3, v + 32'd1, req);
        send_event(3, ~v, req);
        send_event(3, 32'h8000_0000, req);
        send_event(3, 32'h0000_0001, req);
    endtask

    task automatic t_idle;
        write_cfg(2, 0, 32'hA0);
        write_cfg(2, 1, mk_ctrl(0, 1, 7, 1));
        send_event(4, 32'h20, "R11 single hit any");
        @(negedge clk);
        check("R10 idle after hit", hit_o, 8'h00, any_hit_o);
    endtask

    task automatic t_same_cycle;
        logic [7:0] exp;
        for (int i = 0; i < 8; i++) write_cfg(i, 1, 32'h0);
        write_cfg(5, 0, 32'h40);
        write_cfg(5, 1, mk_ctrl(0, 2, 2, 1));
        @(negedge clk);
        ev_valid = 1'b1;
        ev_kind = 3'd1;
        ev_data = 32'h40;
        exp = ref_vec(1, 32'h40);
        cfg_we = 1'b1;
        cfg_addr = {3'd5, 1'b1};
        cfg_wdata = 32'h0;
        @(negedge clk);
        check("R12 old config used", hit_o, exp, any_hit_o);
        ev_valid = 1'b0;
        cfg_we = 1'b0;
        sh_ctrl[5] = 8'h0;
        send_event(1, 32'h40, "R12 new config used");
        write_cfg(6, 0, 32'h40);
        write_cfg(6, 1, mk_ctrl(0, 2, 6, 1));
        write_cfg(6, 0, 32'h41);
        send_event(2, 32'h41, "R12 value write kept control");
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            sh_ctrl[i] = '0;
            sh_val[i] = '0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        t_armed();
        t_triggers();
        t_conds(1'b0, 32'd100, "R5 R6 R7 unsigned");
        t_conds(1'b0, 32'hFFFF_FF00, "R7 unsigned high");
        t_conds(1'b1, 32'hFFFF_FF00, "R8 signed negative");
        t_conds(1'b1, 32'd100, "R8 signed positive");
        t_idle();
        t_same_cycle();
        finish_run();
    end

    initial begin
        #(20 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule